// File: doc/BRIEF.md
# Superframe CRC-12 Generator and Checker with Far-End Error Return

This block protects the payload of a framed digital subscriber line with a 12-bit cyclic redundancy check that is carried one superframe late. One cycle with `bit_en_i` high is one bit position. A shared marker flags the first bit of each superframe, a qualifier flags the protected payload bits (the two bearer channels, the signalling channel and the fourth maintenance bit), and an overhead strobe flags the twelve CRC positions. The transmit side accumulates a CRC over its outgoing protected bits and serves it up bit by bit during the CRC positions of the following superframe. The receive side does the same over incoming bits and captures the twelve received CRC bits. At each superframe start it checks the captured value against the one it computed locally one superframe earlier.

A failed check raises a near-end block error flag for the host. The outcome of every check is also queued as a far-end block error bit. That bit is presented to the transmit framer two superframes later: 1 for a clean block and 0 for an errored one. Framing, bit placement and line coding belong to neighbouring blocks.

Top module: `sf_crc12_febe`

## Requirements
- R1: After the asynchronous reset, `tx_febe_o` is 1 and `nebe_o` and `chk_valid_o` are 0. In the first superframe after reset, `tx_crc_bit_o` is 0 in every CRC position.
- R2: The CRC uses the polynomial x^12+x^11+x^3+x^2+x+1 in a serial register, with feedback = register bit 11 XOR the input bit. The register is cleared at each superframe start. If the superframe-start bit is itself protected, it is the first bit folded in. A superframe whose only protected bit is a single 1 yields 12'h80F.
- R3: Bits with `prot_i` low do not change either CRC, whatever their value. This includes overhead and CRC-position bits.
- R4: The CRC of transmit superframe N is driven on `tx_crc_bit_o`, combinationally, during the CRC positions of superframe N+1. The k-th CRC position (k from 0) carries bit 11-k, so the most significant bit comes first. Any CRC position beyond the twelfth drives 0. A superframe start never coincides with a CRC position.
- R5: Received CRC-position bits are shifted in most significant bit first. At the superframe start that ends superframe N+1, they are compared with the local CRC of received superframe N. `chk_valid_o` is high for the one cycle after such a start. No comparison is made at the first two starts after reset.
- R6: `nebe_o` is high in the same cycle as `chk_valid_o` exactly when the received and local values differ. At all other times it is 0.
- R7: `tx_febe_o` changes only at the edge that registers a superframe start. The result of the comparison made at start K is shown from start K+1 until start K+2: 1 for a match, 0 for a mismatch. A start that makes no comparison enqueues 1.
- R8: Cycles with `bit_en_i` low leave all state unchanged, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | A bit position is present this cycle |
| sf_start_i | input | 1 | This bit is the first of a superframe |
| prot_i | input | 1 | This bit is covered by the CRC |
| crc_slot_i | input | 1 | This bit is a CRC overhead position |
| tx_bit_i | input | 1 | Outgoing line bit |
| rx_bit_i | input | 1 | Incoming line bit |
| tx_crc_bit_o | output | 1 | CRC bit to insert at the current CRC position |
| tx_febe_o | output | 1 | Far-end block error bit to send (1 = clean) |
| chk_valid_o | output | 1 | One-cycle pulse: a block comparison was made |
| nebe_o | output | 1 | Near-end block error, qualified by chk_valid_o |

## Verification
Random superframes vary the number of protected bits, the unprotected noise between them, idle gaps, and the CRC bits fed back on the receive side, which are either correct or corrupted in one position. A correct versus a flipped returned CRC separates a real comparison from a constant match. Runs of errored and clean blocks show the two-superframe lag of the returned error bit. Noise on unprotected bits with unchanged protected data shows that the qualifier is honoured. A superframe carrying a single protected 1 pins the polynomial to a literal value. An extra thirteenth CRC position, and superframes with no protected payload, cover the edges of the serializer and the capture register.

// File: rtl/sf_crc_pkg.sv
package sf_crc_pkg;
  localparam int unsigned CRC_W_DEF = 12;
  localparam logic [CRC_W_DEF-1:0] CRC_POLY_DEF = 12'h80F;  // x^12+x^11+x^3+x^2+x+1
  localparam int unsigned FEBE_DELAY_DEF = 2;                // superframes of return lag
  localparam int unsigned SEEN_W = 2;                        // starts seen, saturating at 2
endpackage

// File: rtl/sf_crc_accum.sv
module sf_crc_accum #(
  parameter int unsigned W = sf_crc_pkg::CRC_W_DEF,
  parameter logic [W-1:0] POLY = sf_crc_pkg::CRC_POLY_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         sf_i,
  input  logic         prot_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic         fb;
  logic [W-1:0] stepped;

  assign fb      = crc_o[W-1] ^ bit_i;
  assign stepped = {crc_o[W-2:0], 1'b0} ^ (fb ? POLY : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_o <= '0;
    end else if (en_i) begin
      if (sf_i)        crc_o <= (prot_i && bit_i) ? POLY : '0;
      else if (prot_i) crc_o <= stepped;
    end
  end

  assert_clear_at_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sf_i && !prot_i) |=> (crc_o == '0));
  assert_unprot_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !sf_i && !prot_i) |=> $stable(crc_o));
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(crc_o));
endmodule

// File: rtl/sf_crc_tx.sv
module sf_crc_tx #(
  parameter int unsigned W = sf_crc_pkg::CRC_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         sf_i,
  input  logic         slot_i,
  input  logic [W-1:0] acc_i,
  output logic         crc_bit_o
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [W-1:0]  hold;
  logic [CW-1:0] cnt;
  logic [CW-1:0] idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold <= '0;
      cnt  <= '0;
    end else if (en_i) begin
      if (sf_i) begin
        hold <= acc_i;
        cnt  <= '0;
      end else if (slot_i && cnt != FULL) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign idx       = LAST - cnt;
  assign crc_bit_o = (slot_i && cnt < FULL) ? hold[idx] : 1'b0;

  assert_hold_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && sf_i) |=> $stable(hold));
  assert_slot_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= FULL);
  assert_overrun_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && cnt == FULL) |-> !crc_bit_o);
endmodule

// File: rtl/sf_crc_rx.sv
module sf_crc_rx #(
  parameter int unsigned W = sf_crc_pkg::CRC_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         sf_i,
  input  logic         slot_i,
  input  logic         bit_i,
  input  logic [W-1:0] acc_i,
  output logic         cmp_now_o,
  output logic         cmp_ok_o,
  output logic         chk_o,
  output logic         err_o
);
  localparam int unsigned SW = sf_crc_pkg::SEEN_W;
  localparam logic [SW-1:0] ARMED = SW'(2);

  logic [W-1:0]  expect_q;
  logic [W-1:0]  cap_q;
  logic [SW-1:0] seen_q;

  assign cmp_now_o = en_i && sf_i && (seen_q == ARMED);
  assign cmp_ok_o  = (cap_q == expect_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      expect_q <= '0;
      cap_q    <= '0;
      seen_q   <= '0;
      chk_o    <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      chk_o <= cmp_now_o;
      err_o <= cmp_now_o && !cmp_ok_o;
      if (en_i) begin
        if (sf_i) begin
          expect_q <= acc_i;
          cap_q    <= '0;
          if (seen_q != ARMED) seen_q <= seen_q + 1'b1;
        end else if (slot_i) begin
          cap_q <= {cap_q[W-2:0], bit_i};
        end
      end
    end
  end

  assert_err_qualified_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> chk_o);
  assert_chk_after_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_o |-> $past(en_i && sf_i));
  assert_expect_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && sf_i) |=> $stable(expect_q));
endmodule

// File: rtl/sf_febe_delay.sv
module sf_febe_delay #(
  parameter int unsigned DEPTH = sf_crc_pkg::FEBE_DELAY_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic cmp_now_i,
  input  logic cmp_ok_i,
  output logic febe_o
);
  logic [DEPTH-1:0] stage_q;
  logic             fresh;

  assign fresh = cmp_now_i ? cmp_ok_i : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stage_q[0] <= 1'b1;
    else if (adv_i) stage_q[0] <= fresh;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stage_q[g] <= 1'b1;
      else if (adv_i) stage_q[g] <= stage_q[g-1];
    end
  end

  assign febe_o = stage_q[DEPTH-1];

  assert_febe_moves_on_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(febe_o));
  assert_no_cmp_no_error_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !cmp_now_i) |=> stage_q[0]);
endmodule

// File: rtl/sf_crc12_febe.sv
module sf_crc12_febe #(
  parameter int unsigned W = sf_crc_pkg::CRC_W_DEF,
  parameter logic [W-1:0] POLY = sf_crc_pkg::CRC_POLY_DEF,
  parameter int unsigned FEBE_DELAY = sf_crc_pkg::FEBE_DELAY_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic sf_start_i,
  input  logic prot_i,
  input  logic crc_slot_i,
  input  logic tx_bit_i,
  input  logic rx_bit_i,
  output logic tx_crc_bit_o,
  output logic tx_febe_o,
  output logic chk_valid_o,
  output logic nebe_o
);
  logic [W-1:0] tx_acc;
  logic [W-1:0] rx_acc;
  logic         cmp_now;
  logic         cmp_ok;
  logic         sf_edge;

  assign sf_edge = bit_en_i && sf_start_i;

  sf_crc_accum #(.W(W), .POLY(POLY)) u_tx_acc (
    .clk_i, .rst_ni, .en_i(bit_en_i), .sf_i(sf_start_i), .prot_i,
    .bit_i(tx_bit_i), .crc_o(tx_acc)
  );

  sf_crc_accum #(.W(W), .POLY(POLY)) u_rx_acc (
    .clk_i, .rst_ni, .en_i(bit_en_i), .sf_i(sf_start_i), .prot_i,
    .bit_i(rx_bit_i), .crc_o(rx_acc)
  );

  sf_crc_tx #(.W(W)) u_tx (
    .clk_i, .rst_ni, .en_i(bit_en_i), .sf_i(sf_start_i), .slot_i(crc_slot_i),
    .acc_i(tx_acc), .crc_bit_o(tx_crc_bit_o)
  );

  sf_crc_rx #(.W(W)) u_rx (
    .clk_i, .rst_ni, .en_i(bit_en_i), .sf_i(sf_start_i), .slot_i(crc_slot_i),
    .bit_i(rx_bit_i), .acc_i(rx_acc), .cmp_now_o(cmp_now), .cmp_ok_o(cmp_ok),
    .chk_o(chk_valid_o), .err_o(nebe_o)
  );

  sf_febe_delay #(.DEPTH(FEBE_DELAY)) u_febe (
    .clk_i, .rst_ni, .adv_i(sf_edge), .cmp_now_i(cmp_now), .cmp_ok_i(cmp_ok),
    .febe_o(tx_febe_o)
  );

  assert_start_not_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sf_edge |-> !crc_slot_i);
  assert_idle_no_check_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> (!chk_valid_o && $stable(tx_febe_o)));
endmodule

// File: tb/tb_sf_crc12_febe.sv
module tb_sf_crc12_febe;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, sf_start = 1'b0, prot = 1'b0, crc_slot = 1'b0;
  logic tx_bit = 1'b0, rx_bit = 1'b0;
  logic tx_crc_bit, tx_febe, chk_valid, nebe;

  always #2.5 clk = ~clk;  // 200 MHz

  sf_crc12_febe dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .sf_start_i(sf_start),
    .prot_i(prot), .crc_slot_i(crc_slot), .tx_bit_i(tx_bit), .rx_bit_i(rx_bit),
    .tx_crc_bit_o(tx_crc_bit), .tx_febe_o(tx_febe), .chk_valid_o(chk_valid),
    .nebe_o(nebe)
  );

  int n_chk = 0, n_err = 0;
  string slot_tag = "R4";

  logic [11:0] m_txacc = '0, m_rxacc = '0, m_txhold = '0, m_rxexp = '0, m_rxcap = '0;
  int m_cnt = 0, m_seen = 0;
  bit m_p1 = 1'b1, m_febe = 1'b1, e_chk = 1'b0, e_nebe = 1'b0;
  logic last_crc_bit;

  function automatic logic [11:0] crc_upd(input logic [11:0] c, input logic b);
    logic fb;
    fb = c[11] ^ b;
    return {c[10:0], 1'b0} ^ (fb ? 12'h80F : 12'h000);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit en, input bit sf, input bit pr, input bit sl, input bit tb, input bit rb);
    @(negedge clk);
    bit_en = en; sf_start = sf; prot = pr; crc_slot = sl; tx_bit = tb; rx_bit = rb;
    #1;
    last_crc_bit = tx_crc_bit;
    if (en && sl)
      check(32'(tx_crc_bit), (m_cnt < 12) ? 32'(m_txhold[11-m_cnt]) : 32'd0, slot_tag, "tx crc bit");
    e_chk = 1'b0; e_nebe = 1'b0;
    if (en) begin
      if (sf) begin
        if (m_seen >= 2) begin
          e_chk = 1'b1;
          e_nebe = (m_rxcap != m_rxexp);
        end
        m_febe = m_p1;
        m_p1 = e_chk ? !e_nebe : 1'b1;
        m_txhold = m_txacc;
        m_rxexp = m_rxacc;
        m_rxcap = '0;
        m_cnt = 0;
        if (m_seen < 2) m_seen++;
        m_txacc = pr ? crc_upd(12'h000, tb) : 12'h000;
        m_rxacc = pr ? crc_upd(12'h000, rb) : 12'h000;
      end else begin
        if (pr) begin
          m_txacc = crc_upd(m_txacc, tb);
          m_rxacc = crc_upd(m_rxacc, rb);
        end
        if (sl) begin
          m_rxcap = {m_rxcap[10:0], rb};
          if (m_cnt < 12) m_cnt++;
        end
      end
    end
    @(posedge clk);
    #1;
    check(32'(chk_valid), 32'(e_chk), en ? "R5" : "R8", "chk_valid");
    check(32'(nebe), 32'(e_nebe), en ? "R6" : "R8", "nebe");
    check(32'(tx_febe), 32'(m_febe), en ? "R7" : "R8", "tx_febe");
  endtask

  task automatic idle_random();
    step(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  task automatic run_sf(input int nprot, input int nnoise, input int nslot, input bit flip, input bit gaps);
    logic [11:0] ret;
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'($urandom), 1'($urandom));
    for (int i = 0; i < nprot; i++) begin
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'($urandom), 1'($urandom));
      for (int j = 0; j < nnoise; j++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'($urandom), 1'($urandom));
      if (gaps && ($urandom % 4 == 0)) idle_random();
    end
    ret = m_rxexp;
    for (int k = 0; k < nslot; k++) begin
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'($urandom),
           (k < 12) ? (ret[11-k] ^ (flip && k == 5)) : 1'($urandom));
      if (gaps && ($urandom % 5 == 0)) idle_random();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R8 watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [11:0] got;
    void'($urandom(32'h5EED));
    #7;
    // R1: reset state
    check(32'(tx_febe), 32'd1, "R1", "febe in reset");
    check(32'(nebe), 32'd0, "R1", "nebe in reset");
    check(32'(chk_valid), 32'd0, "R1", "chk_valid in reset");
    @(negedge clk); rst_n = 1'b1;

    slot_tag = "R1";
    run_sf(8, 0, 12, 1'b0, 1'b0);
    slot_tag = "R4";
    run_sf(20, 0, 12, 1'b0, 1'b0);
    run_sf(20, 0, 12, 1'b0, 1'b1);
    run_sf(15, 0, 12, 1'b1, 1'b0);
    run_sf(15, 0, 12, 1'b0, 1'b0);
    run_sf(15, 0, 12, 1'b0, 1'b0);

    for (int s = 0; s < 40; s++)
      run_sf(int'($urandom % 40), int'($urandom % 3), ($urandom % 6 == 0) ? 13 : 12,
             ($urandom % 4 == 0), 1'b1);

    // R3: unprotected noise must not move the CRC
    slot_tag = "R3";
    for (int s = 0; s < 4; s++) run_sf(10, 3, 12, 1'b0, 1'b1);

    // R2: single protected 1 at the start, then only noise
    slot_tag = "R2";
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'($urandom), 1'($urandom));
    for (int k = 0; k < 12; k++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, m_rxexp[11-k]);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    got = '0;
    for (int k = 0; k < 12; k++) begin
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, m_rxexp[11-k]);
      got = {got[10:0], last_crc_bit};
    end
    check(32'(got), 32'h80F, "R2", "crc of single one");

    // zero-payload superframes and back-to-back errors
    slot_tag = "R4";
    run_sf(0, 0, 12, 1'b0, 1'b0);
    run_sf(0, 2, 12, 1'b1, 1'b0);
    run_sf(5, 0, 12, 1'b1, 1'b0);
    run_sf(5, 0, 12, 1'b0, 1'b0);
    run_sf(5, 0, 12, 1'b0, 1'b0);
    run_sf(5, 0, 12, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule